// File: doc/BRIEF.md
# Prioritized Event Code Encoder

The encoder collects timing event requests and emits at most one 8-bit event code per transmit slot toward a line serializer. There are 256 codes. Codes 0 to 63 each belong to one dedicated hardware trigger input. The inputs are arranged in four groups of 16. Codes 64 to 255 are software events: a host places them in a small first-in first-out queue.

A hardware request is captured on the rising edge of its input and stays pending until its code has been sent, so a one-cycle pulse is never lost. The serializer marks each transmit slot with a one-cycle `slot_i` pulse, and the encoder then picks one request. Any pending hardware request wins over the software queue. Among hardware requests the lowest input index wins. When no request is pending the slot carries code 0, the null code. Requests that are not picked are held for later slots.

Top module: `evt_code_encoder`

## Requirements
- R1: During and right after reset, `code_vld_o` is 0, `code_o` is 0 and `sw_ovf_o` is 0.
- R2: Each cycle in which `slot_i` is high is followed, in the next cycle, by exactly one cycle of `code_vld_o` high with the chosen code on `code_o`. `code_vld_o` is never high in any other cycle.
- R3: A slot with no pending hardware request and an empty software queue carries code 0.
- R4: A hardware input is latched on its rising edge. A one-cycle pulse produces exactly one code. An input held high produces only one code, however many slots pass.
- R5: Among pending hardware requests, the lowest input index is sent first, and this also holds across the 16-input group boundaries. Input i is sent as code i.
- R6: Every pending hardware request is sent before the head of the software queue.
- R7: Software codes leave in the order they were written, with the code value unchanged.
- R8: A software write of a code below 64 is discarded and never reaches the output.
- R9: A write of a code of 64 or more while the queue holds `FIFO_DEPTH` entries is discarded and sets `sw_ovf_o`. `sw_ovf_o` then stays at 1 until reset. A write of a code below 64 never sets `sw_ovf_o`.
- R10: A rising edge on a hardware input in the same cycle as `slot_i` is not served in that slot but in a later one. A software write in the same cycle as `slot_i` to an empty queue is likewise not served in that slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_i | input | 1 | One-cycle pulse marking a transmit slot |
| hw_trig_i | input | 64 | Hardware trigger inputs; bit i requests code i |
| sw_wr_i | input | 1 | Host write strobe for the software queue |
| sw_code_i | input | 8 | Code written by the host |
| code_o | output | 8 | Event code sent in the last slot |
| code_vld_o | output | 1 | One-cycle strobe: `code_o` holds a new code |
| sw_ovf_o | output | 1 | Sticky flag: a software write was dropped because the queue was full |

## Verification
The cases of interest are those where a request and a transmit slot fall in the same cycle. In one case a hardware rising edge coincides with `slot_i`. In another a host write to an empty queue coincides with `slot_i`. A third is a host write in the same cycle as a slot that pops the queue. The bench produces each of these by driving the trigger or write on the very negative edge where it raises `slot_i`. A reference model written from the requirements predicts which code each slot should carry, and a scoreboard compares that prediction with every `code_vld_o` strobe.

// File: rtl/evt_enc_pkg.sv
// Package: widths and constants shared by the event code encoder.
// Assumes an 8-bit code space with the lowest codes reserved for hardware.
package evt_enc_pkg;
    localparam int CODE_W   = 8;
    localparam int HW_CODES = 64;
    localparam int GRP_SIZE = 16;
    typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/evt_grp_prio.sv
// Module: fixed-priority encoder for one group of request lines.
// Reports whether any line is set and the index of the lowest set line.
// Assumes W is at least 2. Purely combinational.
module evt_grp_prio #(
    parameter int W     = 16,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     req_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan from the top down so that the lowest set index is the last one written.
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
        hit_o = |req_i;
    end
endmodule

// File: rtl/evt_hw_arb.sv
// Module: hardware request capture and arbitration.
// Latches a rising edge on each trigger into a pending bit. The pending bit is
// cleared when its index is granted; a new edge in the same cycle wins over the clear.
// One priority encoder runs per group, then a second level picks the lowest
// non-empty group. Assumes GRP is a power of two and divides HW_N.
module evt_hw_arb #(
    parameter int HW_N     = 64,
    parameter int GRP      = 16,
    parameter int HW_IDX_W = $clog2(HW_N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HW_N-1:0]     trig_i,
    input  logic                grant_i,
    output logic                any_o,
    output logic [HW_IDX_W-1:0] idx_o
);
    localparam int NGRP  = HW_N / GRP;
    localparam int GRP_W = $clog2(GRP);

    logic [HW_N-1:0]  trig_q;
    logic [HW_N-1:0]  pend_q;
    logic [HW_N-1:0]  rise;
    logic [HW_N-1:0]  clr_mask;
    logic [NGRP-1:0]  grp_hit;
    logic [GRP_W-1:0] grp_idx [NGRP];

    assign rise = trig_i & ~trig_q;

    // Remember the previous level of each trigger input for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= '0;
        else        trig_q <= trig_i;
    end

    // Build the one-hot clear mask for the granted index.
    always_comb begin
        clr_mask = '0;
        if (grant_i) clr_mask[idx_o] = 1'b1;
    end

    // Pending set: keep the bits not granted, then add new rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_mask) | rise;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        evt_grp_prio #(.W(GRP), .IDX_W(GRP_W)) u_prio (
            .req_i (pend_q[g*GRP +: GRP]),
            .hit_o (grp_hit[g]),
            .idx_o (grp_idx[g])
        );
    end

    // Second level: the lowest group with a hit supplies the upper index bits.
    always_comb begin
        idx_o = '0;
        for (int g = NGRP - 1; g >= 0; g--) begin
            if (grp_hit[g]) idx_o = HW_IDX_W'(g * GRP) | HW_IDX_W'(grp_idx[g]);
        end
        any_o = |grp_hit;
    end
endmodule

// File: rtl/evt_sw_fifo.sv
// Module: first-in first-out queue for software event codes.
// The head entry is visible combinationally on rdata_o. A write is ignored
// while the queue is full, and a read is ignored while it is empty.
// The storage array has no reset; only the pointers and the count are reset.
module evt_sw_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         rd_i,
    output logic [W-1:0] rdata_o,
    output logic         empty_o,
    output logic         full_o,
    output logic [CW-1:0] cnt_o
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr_q;
    logic [AW-1:0] rptr_q;
    logic [CW-1:0] cnt_q;
    logic          do_wr;
    logic          do_rd;

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CW'(DEPTH));
    assign cnt_o   = cnt_q;
    assign do_wr   = wr_i & ~full_o;
    assign do_rd   = rd_i & ~empty_o;
    assign rdata_o = mem[rptr_q];

    // Store accepted write data at the write pointer.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr_q] <= wdata_i;
    end

    // Advance the pointers with wrap at DEPTH and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_wr) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
            if (do_rd) rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/evt_code_encoder.sv
// Module: prioritized event code encoder (top).
// On each slot_i pulse it sends one code: the lowest pending hardware index if
// there is one, else the software queue head, else the null code 0. The code
// is registered and appears with code_vld_o one cycle after slot_i.
// Assumes slot_i, the triggers and the host writes are all synchronous to clk.
module evt_code_encoder
    import evt_enc_pkg::*;
#(
    parameter int HW_N       = HW_CODES,
    parameter int GRP_N      = GRP_SIZE,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_i,
    input  logic [HW_N-1:0]   hw_trig_i,
    input  logic              sw_wr_i,
    input  logic [CODE_W-1:0] sw_code_i,
    output logic [CODE_W-1:0] code_o,
    output logic              code_vld_o,
    output logic              sw_ovf_o
);
    localparam int HW_IDX_W = $clog2(HW_N);
    localparam int CNT_W    = $clog2(FIFO_DEPTH + 1);

    logic                hw_any;
    logic [HW_IDX_W-1:0] hw_idx;
    logic                hw_grant;
    logic                code_ok;
    logic                fifo_wr;
    logic                fifo_rd;
    code_t               fifo_head;
    logic                fifo_empty;
    logic                fifo_full;
    logic [CNT_W-1:0]    fifo_cnt;
    code_t               sel_code;

    assign code_ok  = (sw_code_i >= CODE_W'(HW_N));
    assign fifo_wr  = sw_wr_i & code_ok;
    assign hw_grant = slot_i & hw_any;
    assign fifo_rd  = slot_i & ~hw_any;

    evt_hw_arb #(.HW_N(HW_N), .GRP(GRP_N), .HW_IDX_W(HW_IDX_W)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (hw_trig_i),
        .grant_i (hw_grant),
        .any_o   (hw_any),
        .idx_o   (hw_idx)
    );

    evt_sw_fifo #(.DEPTH(FIFO_DEPTH), .W(CODE_W), .CW(CNT_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (fifo_wr),
        .wdata_i (sw_code_i),
        .rd_i    (fifo_rd),
        .rdata_o (fifo_head),
        .empty_o (fifo_empty),
        .full_o  (fifo_full),
        .cnt_o   (fifo_cnt)
    );

    // Choose the code for this slot: hardware first, then software, then null.
    always_comb begin
        if (hw_any)           sel_code = {{(CODE_W-HW_IDX_W){1'b0}}, hw_idx};
        else if (!fifo_empty) sel_code = fifo_head;
        else                  sel_code = '0;
    end

    // Register the chosen code and strobe it toward the serializer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o     <= '0;
            code_vld_o <= 1'b0;
        end else begin
            code_vld_o <= slot_i;
            if (slot_i) code_o <= sel_code;
        end
    end

    // Sticky flag for a valid software write dropped by a full queue.
    always_ff @(posedge clk) begin
        if (!rst_n)                     sw_ovf_o <= 1'b0;
        else if (fifo_wr && fifo_full)  sw_ovf_o <= 1'b1;
    end
endmodule

// File: rtl/evt_code_encoder_chk.sv
// Module: assertion checker attached to the encoder top by bind.
// Watches the slot strobe, the output register, the sticky flag and the
// occupancy of the software queue.
module evt_code_encoder_chk #(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slot_i,
    input logic             code_vld_o,
    input logic [7:0]       code_o,
    input logic             sw_ovf_o,
    input logic             hw_any,
    input logic [CNT_W-1:0] fifo_cnt
);
    // R2
    vld_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_i |=> code_vld_o);
    // R2
    no_stray_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_i |=> !code_vld_o);
    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_ovf_o |=> sw_ovf_o);
    // R6
    hw_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_i && hw_any) |=> (code_o < 8'd64));
    // R3
    null_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_i && !hw_any && fifo_cnt == '0) |=> (code_o == 8'd0));
    // R9
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(FIFO_DEPTH));
endmodule

bind evt_code_encoder evt_code_encoder_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_i     (slot_i),
    .code_vld_o (code_vld_o),
    .code_o     (code_o),
    .sw_ovf_o   (sw_ovf_o),
    .hw_any     (hw_any),
    .fifo_cnt   (fifo_cnt)
);

// File: tb/evt_code_encoder_tb.sv
`timescale 1ns/1ps
module evt_code_encoder_tb;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_i = 1'b0;
    logic [63:0] hw_trig_i = '0;
    logic        sw_wr_i = 1'b0;
    logic [7:0]  sw_code_i = '0;
    logic [7:0]  code_o;
    logic        code_vld_o;
    logic        sw_ovf_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur_tag = "R3";

    typedef struct { logic [7:0] code; string tag; } exp_t;
    exp_t exp_q[$];

    // Reference model state
    bit         m_pend [64];
    bit         m_prev [64];
    logic [7:0] m_q[$];
    bit         m_ovf;
    bit         m_slot_d;

    always #2.5 clk = ~clk;

    evt_code_encoder #(.FIFO_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .slot_i(slot_i), .hw_trig_i(hw_trig_i),
        .sw_wr_i(sw_wr_i), .sw_code_i(sw_code_i), .code_o(code_o),
        .code_vld_o(code_vld_o), .sw_ovf_o(sw_ovf_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model, evaluated from the requirements at each rising edge
    always @(posedge clk) begin
        int sz0;
        bit found;
        exp_t e;
        if (!rst_n) begin
            foreach (m_pend[i]) begin m_pend[i] = 0; m_prev[i] = 0; end
            m_q.delete();
            m_ovf = 0;
            m_slot_d = 0;
        end else begin
            sz0 = m_q.size();
            m_slot_d = slot_i;
            if (slot_i) begin
                found = 0;
                for (int i = 0; i < 64; i++) begin
                    if (!found && m_pend[i]) begin
                        found = 1; m_pend[i] = 0;
                        e.code = 8'(i); e.tag = cur_tag; exp_q.push_back(e);
                    end
                end
                if (!found) begin
                    if (sz0 > 0) e.code = m_q.pop_front();
                    else         e.code = 8'd0;
                    e.tag = cur_tag;
                    exp_q.push_back(e);
                end
            end
            for (int i = 0; i < 64; i++) begin
                if (hw_trig_i[i] && !m_prev[i]) m_pend[i] = 1;
                m_prev[i] = hw_trig_i[i];
            end
            if (sw_wr_i && sw_code_i >= 8'd64) begin
                if (sz0 == DEPTH) m_ovf = 1;
                else              m_q.push_back(sw_code_i);
            end
        end
    end

    // Scoreboard monitor: compare each strobe with the next expected code
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            chk(code_vld_o == m_slot_d, "R2", code_vld_o, m_slot_d);
            if (code_vld_o) begin
                if (exp_q.size() == 0) chk(0, "R2", code_o, -1);
                else begin
                    e = exp_q.pop_front();
                    chk(code_o == e.code, e.tag, code_o, e.code);
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_slot();
        slot_i = 1'b1; cyc(1); slot_i = 1'b0; cyc(1);
    endtask

    task automatic pulse(input int idx);
        hw_trig_i[idx] = 1'b1; cyc(1); hw_trig_i[idx] = 1'b0;
    endtask

    task automatic sw_write(input logic [7:0] c);
        sw_wr_i = 1'b1; sw_code_i = c; cyc(1); sw_wr_i = 1'b0;
    endtask

    initial begin
        cyc(3);
        // R1: reset state
        chk(code_vld_o == 0, "R1", code_vld_o, 0);
        chk(code_o == 0, "R1", code_o, 0);
        chk(sw_ovf_o == 0, "R1", sw_ovf_o, 0);
        rst_n = 1'b1;
        cyc(1);
        chk(code_vld_o == 0 && code_o == 0 && sw_ovf_o == 0, "R1", code_o, 0);

        // R3: empty slot sends null code
        cur_tag = "R3"; do_slot();

        // R4: one-cycle pulse is held until sent
        cur_tag = "R4"; pulse(5); cyc(4); do_slot(); do_slot();

        // R5: lowest index first, across group boundaries
        cur_tag = "R5";
        hw_trig_i[40] = 1; hw_trig_i[3] = 1; hw_trig_i[17] = 1;
        hw_trig_i[16] = 1; hw_trig_i[15] = 1; hw_trig_i[48] = 1; hw_trig_i[47] = 1;
        cyc(1); hw_trig_i = '0; cyc(1);
        repeat (8) do_slot();

        // R6, R7: hardware before software, software in order
        cur_tag = "R6";
        sw_write(8'd100); sw_write(8'd200); pulse(63); cyc(1);
        do_slot();
        cur_tag = "R7"; do_slot(); do_slot(); do_slot();

        // R8: low codes rejected, code 64 accepted
        cur_tag = "R8";
        sw_write(8'd10); sw_write(8'd63); sw_write(8'd0); sw_write(8'd64);
        do_slot(); do_slot();

        // R4: level held high yields one code only
        cur_tag = "R4";
        hw_trig_i[7] = 1; cyc(2); do_slot(); do_slot(); do_slot();
        hw_trig_i[7] = 0; cyc(1);

        // R9: overflow on full queue, sticky
        cur_tag = "R9";
        for (int i = 0; i < DEPTH + 1; i++) sw_write(8'(70 + i));
        sw_write(8'd5);
        cyc(1);
        chk(sw_ovf_o == 1, "R9", sw_ovf_o, 1);
        for (int i = 0; i < DEPTH + 1; i++) do_slot();
        chk(sw_ovf_o == 1, "R9", sw_ovf_o, 1);

        // R10: edge coincides with slot; write to empty queue coincides with slot
        cur_tag = "R10";
        hw_trig_i[2] = 1; slot_i = 1; cyc(1); slot_i = 0; hw_trig_i[2] = 0; cyc(1);
        do_slot();
        sw_wr_i = 1; sw_code_i = 8'd150; slot_i = 1; cyc(1);
        sw_wr_i = 0; slot_i = 0; cyc(1);
        do_slot();
        // write in the same cycle as a slot that pops the queue
        sw_write(8'd90);
        sw_wr_i = 1; sw_code_i = 8'd91; slot_i = 1; cyc(1);
        sw_wr_i = 0; slot_i = 0; cyc(1);
        do_slot(); do_slot();

        cyc(3);
        chk(exp_q.size() == 0, "R2", exp_q.size(), 0);
        chk(sw_ovf_o == m_ovf, "R9", sw_ovf_o, m_ovf);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule